// File: doc/BRIEF.md
# Ten-Instruction Accumulator Datapath

This block is the execute stage of a small accumulator machine. Each clock cycle it can accept one instruction, given as a 4-bit code with a valid strobe. The instruction acts on an accumulator A, a single general register R, an 8-bit input bus and an 8-bit output register. The instruction set covers four kinds of operation: loads from the input bus into A or R, a copy of A into R, stores of A or R to the output register, and ALU operations on A. The ALU operations are add, OR, AND and complement.

Instruction fetch and sequencing belong to the surrounding logic. That logic presents one code per cycle and reads the result on the output bus. An output-valid pulse marks each cycle that follows a store. A and R are also brought out so that their state can be observed. There are no flags, no carry and no branching.

Top module: `acc_datapath`

## Requirements
- R1: While the active-low synchronous reset is sampled low at a clock edge, A, R and the output bus become 0 and output-valid becomes 0.
- R2: Codes 1 and 6 load the input bus value into A.
- R3: Code 2 copies A into R and leaves A unchanged.
- R4: Code 3 puts R on the output bus and code 4 puts A on it. Output-valid is high in the cycle after either store and low in the cycle after any other cycle.
- R5: Code 5 loads the input bus value into R.
- R6: Code 7 writes (A + R) mod 256 into A.
- R7: Code 8 writes A OR R into A, and code 9 writes A AND R into A.
- R8: Code 10 writes the bitwise complement of A into A.
- R9: R changes only on codes 2 and 5.
- R10: Codes 0 and 11 to 15 change neither A, R nor the output bus.
- R11: A cycle with the valid strobe low changes no register and leaves output-valid low in the next cycle.
- R12: The output bus holds its value in every cycle where output-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Instruction code |
| op_valid | input | 1 | Instruction present this cycle |
| in_bus | input | 8 | Input port data |
| out_bus | output | 8 | Output port register |
| out_valid | output | 1 | One-cycle pulse after a store |
| acc_q | output | 8 | Current accumulator value |
| reg_q | output | 8 | Current general register value |

## Verification
The assertions assume that op_code, op_valid and in_bus are known, non-X values at every rising edge while reset is released. They also assume that reset is held for at least one edge before it is released. The bench meets both assumptions: it holds reset from time zero, and it changes inputs only on the falling edge, always to defined values. The bench sweeps every code with the strobe both high and low, across 256 accumulator values paired with varied R and input values, so that each assertion's antecedent is exercised many times.

// File: rtl/acc_pkg.sv
// Shared types for the accumulator datapath.
// Assumes a 4-bit instruction code; codes not listed here are no-ops.
package acc_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_LD_A_IMM = 4'd1;
    localparam logic [OP_W-1:0] OP_MOV_R_A  = 4'd2;
    localparam logic [OP_W-1:0] OP_ST_R     = 4'd3;
    localparam logic [OP_W-1:0] OP_ST_A     = 4'd4;
    localparam logic [OP_W-1:0] OP_LD_R_IN  = 4'd5;
    localparam logic [OP_W-1:0] OP_LD_A_IN  = 4'd6;
    localparam logic [OP_W-1:0] OP_ADD      = 4'd7;
    localparam logic [OP_W-1:0] OP_OR       = 4'd8;
    localparam logic [OP_W-1:0] OP_AND      = 4'd9;
    localparam logic [OP_W-1:0] OP_CPL      = 4'd10;

    typedef enum logic [2:0] {
        ASRC_IN  = 3'd0,
        ASRC_ADD = 3'd1,
        ASRC_OR  = 3'd2,
        ASRC_AND = 3'd3,
        ASRC_CPL = 3'd4
    } a_src_e;

    typedef struct packed {
        logic   a_we;
        a_src_e a_src;
        logic   r_we;
        logic   r_from_in;
        logic   o_we;
        logic   o_from_r;
    } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
// Instruction decoder: maps a code and strobe to register write enables
// and source selects. Assumes op_code is known whenever op_valid is high.
module acc_decode
    import acc_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    input  logic            op_valid,
    output ctrl_t           ctrl
);

    // Purpose: one control word per instruction; all enables low otherwise.
    always_comb begin
        ctrl = '{a_we: 1'b0, a_src: ASRC_IN, r_we: 1'b0,
                 r_from_in: 1'b0, o_we: 1'b0, o_from_r: 1'b0};
        if (op_valid) begin
            case (op_code)
                OP_LD_A_IMM, OP_LD_A_IN: begin
                    ctrl.a_we  = 1'b1;
                    ctrl.a_src = ASRC_IN;
                end
                OP_MOV_R_A: begin
                    ctrl.r_we      = 1'b1;
                    ctrl.r_from_in = 1'b0;
                end
                OP_ST_R: begin
                    ctrl.o_we     = 1'b1;
                    ctrl.o_from_r = 1'b1;
                end
                OP_ST_A: begin
                    ctrl.o_we     = 1'b1;
                    ctrl.o_from_r = 1'b0;
                end
                OP_LD_R_IN: begin
                    ctrl.r_we      = 1'b1;
                    ctrl.r_from_in = 1'b1;
                end
                OP_ADD: begin
                    ctrl.a_we  = 1'b1;
                    ctrl.a_src = ASRC_ADD;
                end
                OP_OR: begin
                    ctrl.a_we  = 1'b1;
                    ctrl.a_src = ASRC_OR;
                end
                OP_AND: begin
                    ctrl.a_we  = 1'b1;
                    ctrl.a_src = ASRC_AND;
                end
                OP_CPL: begin
                    ctrl.a_we  = 1'b1;
                    ctrl.a_src = ASRC_CPL;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Accumulator source mux and ALU: computes the value to write into A.
// Assumes the addition wraps at DATA_W bits; no carry is produced.
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  a_src_e            a_src,
    input  logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] in_val,
    output logic [DATA_W-1:0] acc_next
);

    // Purpose: select input bus or one ALU result for A.
    always_comb begin
        case (a_src)
            ASRC_ADD: acc_next = acc_val + reg_val;
            ASRC_OR:  acc_next = acc_val | reg_val;
            ASRC_AND: acc_next = acc_val & reg_val;
            ASRC_CPL: acc_next = ~acc_val;
            default:  acc_next = in_val;
        endcase
    end

endmodule

// File: rtl/acc_out_port.sv
// Output port register with a one-cycle valid pulse after each store.
// Assumes o_we is a single-cycle request; the value holds otherwise.
module acc_out_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              o_we,
    input  logic [DATA_W-1:0] o_data,
    output logic [DATA_W-1:0] out_bus,
    output logic              out_valid
);

    // Purpose: capture stored data and flag it for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bus   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= o_we;
            if (o_we) out_bus <= o_data;
        end
    end

    // R12: with no store the port keeps its value.
    a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> $stable(out_bus));

endmodule

// File: rtl/acc_datapath.sv
// Top of the accumulator datapath: decode, ALU, A and R registers, output port.
// Assumes one instruction per cycle, qualified by op_valid; reset is synchronous.
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_code,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] in_bus,
    output logic [DATA_W-1:0] out_bus,
    output logic              out_valid,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] reg_q
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] acc_next;
    logic [DATA_W-1:0] o_data;

    acc_decode u_decode (
        .op_code (op_code),
        .op_valid(op_valid),
        .ctrl    (ctrl)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .a_src   (ctrl.a_src),
        .acc_val (acc_q),
        .reg_val (reg_q),
        .in_val  (in_bus),
        .acc_next(acc_next)
    );

    // Purpose: pick the register driven onto the output port.
    always_comb o_data = ctrl.o_from_r ? reg_q : acc_q;

    acc_out_port #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .o_we     (ctrl.o_we),
        .o_data   (o_data),
        .out_bus  (out_bus),
        .out_valid(out_valid)
    );

    // Purpose: accumulator and general register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            reg_q <= '0;
        end else begin
            if (ctrl.a_we) acc_q <= acc_next;
            if (ctrl.r_we) reg_q <= ctrl.r_from_in ? in_bus : acc_q;
        end
    end

    // R1: reset clears all state.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && reg_q == '0 && out_bus == '0 && !out_valid));

    // R4: a store is followed by a valid pulse.
    a_r4_store_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ST_R || op_code == OP_ST_A)) |=> out_valid);

    // R6: addition wraps.
    a_r6_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADD) |=>
        acc_q == DATA_W'($past(acc_q) + $past(reg_q)));

    // R8: complement.
    a_r8_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CPL) |=> acc_q == ~$past(acc_q));

    // R9: R holds except on its two writing codes.
    a_r9_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && (op_code == OP_MOV_R_A || op_code == OP_LD_R_IN))
        |=> $stable(reg_q));

    // R10: unused codes change nothing.
    a_r10_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd0 || op_code > OP_CPL)) |=>
        ($stable(acc_q) && $stable(reg_q) && $stable(out_bus) && !out_valid));

    // R11: no strobe, no effect.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_q) && $stable(reg_q) && !out_valid));

endmodule

// File: tb/acc_datapath_tb_top.sv
module acc_datapath_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic       op_valid = 1'b0;
    logic [7:0] in_bus = 8'd0;
    logic [7:0] out_bus, acc_q, reg_q;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_a = 8'd0, exp_r = 8'd0, exp_o = 8'd0;
    logic       exp_v = 1'b0;

    always #2 clk = ~clk;

    acc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_valid(op_valid),
        .in_bus(in_bus), .out_bus(out_bus), .out_valid(out_valid),
        .acc_q(acc_q), .reg_q(reg_q)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op, input logic v);
        if (!v) return "R11";
        case (op)
            4'd1, 4'd6: return "R2";
            4'd2:       return "R3";
            4'd3, 4'd4: return "R4";
            4'd5:       return "R5";
            4'd7:       return "R6";
            4'd8, 4'd9: return "R7";
            4'd10:      return "R8";
            default:    return "R10";
        endcase
    endfunction

    // Apply one instruction, update the model, check after the edge.
    task automatic run_op(input logic [3:0] op, input logic v, input logic [7:0] din);
        string t;
        logic  st, rw;
        @(negedge clk);
        op_code = op; op_valid = v; in_bus = din;
        t  = op_tag(op, v);
        st = v && (op == 4'd3 || op == 4'd4);
        rw = v && (op == 4'd2 || op == 4'd5);
        if (v) begin
            case (op)
                4'd1, 4'd6: exp_a = din;
                4'd2:       exp_r = exp_a;
                4'd3:       exp_o = exp_r;
                4'd4:       exp_o = exp_a;
                4'd5:       exp_r = din;
                4'd7:       exp_a = exp_a + exp_r;
                4'd8:       exp_a = exp_a | exp_r;
                4'd9:       exp_a = exp_a & exp_r;
                4'd10:      exp_a = ~exp_a;
                default: ;
            endcase
        end
        exp_v = st;
        @(posedge clk);
        #1;
        check(t, acc_q, exp_a);
        check(rw ? t : "R9", reg_q, exp_r);
        check(st ? "R4" : "R12", out_bus, exp_o);
        check(st ? "R4" : t, {7'd0, out_valid}, {7'd0, exp_v});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b1; op_code = 4'd6; in_bus = 8'h3C;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1; op_valid = 1'b0;
        exp_a = 0; exp_r = 0; exp_o = 0; exp_v = 0;
        check("R1", acc_q, 8'd0);
        check("R1", reg_q, 8'd0);
        check("R1", out_bus, 8'd0);
        check("R1", {7'd0, out_valid}, 8'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset();
        // R3 then R4: copy A into R, store R and A.
        run_op(4'd1, 1'b1, 8'h5A);
        run_op(4'd2, 1'b1, 8'h00);
        run_op(4'd3, 1'b1, 8'hFF);
        run_op(4'd4, 1'b1, 8'h11);
        run_op(4'd4, 1'b1, 8'h11);
        run_op(4'd0, 1'b1, 8'h22);
        // Near-exhaustive sweep over A values, all codes, both strobes.
        for (int i = 0; i < 256; i++) begin
            for (int op = 0; op < 16; op++) begin
                for (int v = 0; v < 2; v++) begin
                    run_op((i % 2) ? 4'd1 : 4'd6, 1'b1, 8'(i));
                    run_op(4'd5, 1'b1, 8'(i * 37 + 11 + op));
                    run_op(4'(op), v[0], ~8'(i));
                end
            end
        end
        // Add wrap boundary: 0xFF + 0x01 gives 0 (R6).
        run_op(4'd1, 1'b1, 8'hFF);
        run_op(4'd5, 1'b1, 8'h01);
        run_op(4'd7, 1'b1, 8'h00);
        check("R6", acc_q, 8'h00);
        // Reset with nonzero state (R1).
        run_op(4'd1, 1'b1, 8'hA7);
        run_op(4'd2, 1'b1, 8'h00);
        run_op(4'd4, 1'b1, 8'h00);
        do_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule